// File: doc/BRIEF.md
# Programmable-Threshold FIFO

This block is a single-clock first-in first-out buffer of 256 words, each 18 bits wide. It drives five active-low status outputs: empty, full, half-full, almost-empty and almost-full. The almost-empty and almost-full thresholds come from two 12-bit offset registers, and these can be changed at run time.

A select input (`cfg_n`) chooses what the write and read cycles reach. With `cfg_n` high, cycles go to the storage array. With `cfg_n` low, write cycles load the offset registers from `din` and read cycles return the offsets on `dout`. In both directions the empty offset comes first and the full offset comes second, and each sequence then starts again. A read with the read enable held high leaves the output register unchanged.

Top module: `thresh_fifo`

## Requirements
- R1: While `rst_n` is low, and after its release: `dout` is zero, `empty_n` and `aempty_n` are low, `full_n`, `half_n` and `afull_n` are high, and both offsets are 31.
- R2: When `cfg_n`=1 and `wr_n`=0 on a clock edge, `din` is stored if the FIFO is not full. When `cfg_n`=1 and `rd_n`=0 on a clock edge, the oldest word moves to `dout` at that edge if the FIFO is not empty. Words leave in the order they were written.
- R3: When `cfg_n`=0 and `wr_n`=0 on a clock edge, `din[11:0]` loads the next offset in the sequence: the empty offset first, then the full offset, then the empty offset again. Reset returns the sequence to the empty offset.
- R4: When `cfg_n`=0 and `rd_n`=0 on a clock edge, `dout` takes the next offset in the sequence. The empty offset comes first, then the full offset, and the sequence then wraps. The offset appears on `dout[11:0]` and `dout[17:12]` is zero.
- R5: `empty_n` is low when the FIFO holds 0 words. A storage read while the FIFO is empty leaves `dout` and the word count unchanged.
- R6: `full_n` is low when the FIFO holds 256 words. A storage write while the FIFO is full is dropped.
- R7: `half_n` is low when the FIFO holds 129 words or more.
- R8: `aempty_n` is low when the word count is at most the empty offset, and high when the count is above it.
- R9: `afull_n` is low when the word count is at least 256 minus the full offset.
- R10: A clock edge with `rd_n`=1 leaves `dout` unchanged.
- R11: A storage read and a storage write in the same cycle, when the FIFO is neither empty nor full, leave the word count unchanged and keep the word order.
- R12: An offset-register write cycle changes neither the stored words nor the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the read and write sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_n | input | 1 | Low: cycles reach the offset registers. High: cycles reach the storage array |
| wr_n | input | 1 | Active-low write enable |
| rd_n | input | 1 | Active-low read enable |
| din | input | 18 | Write data; bits 11:0 carry an offset value |
| dout | output | 18 | Output register holding the read word or the read-back offset |
| empty_n | output | 1 | Low when the FIFO holds no words |
| full_n | output | 1 | Low when the FIFO holds 256 words |
| half_n | output | 1 | Low when the FIFO holds 129 words or more |
| aempty_n | output | 1 | Low when the word count is at most the empty offset |
| afull_n | output | 1 | Low when the word count is at least 256 minus the full offset |

## Verification
`dout` is registered, so a read or readback issued before edge k shows its result straight after edge k. The five flags are decoded from the registered word count, so a write or read at edge k moves them straight after the same edge. The bench applies every stimulus at a falling edge and samples at the next falling edge, half a cycle after the rising edge that acts on it. It compares against a word queue, a count and a pair of offsets kept in the bench. Each flag is checked at every count as the FIFO fills and drains. The boundary counts are therefore all covered: the empty offset and one above it, 129, 256 minus the full offset, and 256.

// File: rtl/thresh_fifo.sv
module thresh_fifo #(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 256,
  parameter int OFS_W   = 12,
  parameter int OFS_DEF = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             aempty_n,
  output logic             afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int SW = (OFS_W > CW ? OFS_W : CW) + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic [OFS_W-1:0] eofs, fofs;
  logic             wsel, rsel;

  wire is_empty = (cnt == '0);
  wire is_full  = (cnt == CW'(DEPTH));
  wire do_wr    = cfg_n && !wr_n && !is_full;
  wire do_rd    = cfg_n && !rd_n && !is_empty;
  wire ofs_wr   = !cfg_n && !wr_n;
  wire ofs_rd   = !cfg_n && !rd_n;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      dout <= '0;
      eofs <= OFS_W'(OFS_DEF);
      fofs <= OFS_W'(OFS_DEF);
      wsel <= 1'b0;
      rsel <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) begin
        rptr <= rptr + 1'b1;
        dout <= mem[rptr];
      end
      if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
      if (ofs_wr) begin
        if (wsel) fofs <= din[OFS_W-1:0];
        else      eofs <= din[OFS_W-1:0];
        wsel <= ~wsel;
      end
      if (ofs_rd) begin
        dout <= {{(WIDTH-OFS_W){1'b0}}, (rsel ? fofs : eofs)};
        rsel <= ~rsel;
      end
    end
  end

  assign empty_n  = !is_empty;
  assign full_n   = !is_full;
  assign half_n   = !(cnt > CW'(DEPTH / 2));
  assign aempty_n = SW'(cnt) > SW'(eofs);
  assign afull_n  = !((SW'(cnt) + SW'(fofs)) >= SW'(DEPTH));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && cfg_n && !wr_n && rd_n) |=> !full_n); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && cfg_n && !rd_n) |=> $stable(dout)); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> $stable(dout)); // R10
  AST_SIMUL: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n && full_n && cfg_n && !wr_n && !rd_n) |=> $stable(cnt)); // R11
  AST_CFG_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_n) |=> $stable(cnt)); // R12
  AST_EMPTY_AE: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n); // R8
  AST_FULL_AF: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (!afull_n && !half_n)); // R9
endmodule

// File: tb/thresh_fifo_tb.sv
module thresh_fifo_tb_top;
  logic clk = 0, rst_n = 0, cfg_n = 1, wr_n = 1, rd_n = 1;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic empty_n, full_n, half_n, aempty_n, afull_n;
  int total = 0, bad = 0;
  int cnt_m = 0, eofs_m = 31, fofs_m = 31;
  logic [17:0] q[$];
  logic [17:0] last;
  bit done = 0;

  always #5 clk = ~clk;

  thresh_fifo dut_i (.clk(clk), .rst_n(rst_n), .cfg_n(cfg_n), .wr_n(wr_n), .rd_n(rd_n),
    .din(din), .dout(dout), .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic r, input logic [17:0] d);
    cfg_n = s; wr_n = w; rd_n = r; din = d;
    @(posedge clk);
    @(negedge clk);
    cfg_n = 1; wr_n = 1; rd_n = 1;
  endtask

  task automatic flags(input string tag);
    check({tag, " R5 empty_n"}, empty_n, cnt_m != 0);
    check({tag, " R6 full_n"}, full_n, cnt_m != 256);
    check({tag, " R7 half_n"}, half_n, !(cnt_m >= 129));
    check({tag, " R8 aempty_n"}, aempty_n, cnt_m > eofs_m);
    check({tag, " R9 afull_n"}, afull_n, !(cnt_m >= 256 - fofs_m));
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(1, 1, 1, '0);
    cyc(1, 1, 1, '0);
    rst_n = 1;
    cnt_m = 0; eofs_m = 31; fofs_m = 31; q.delete();
  endtask

  task automatic fwrite(input logic [17:0] d);
    cyc(1, 0, 1, d);
    if (cnt_m < 256) begin q.push_back(d); cnt_m++; end
  endtask

  task automatic fread(input string tag);
    logic [17:0] e;
    e = (q.size() > 0) ? q.pop_front() : last;
    if (cnt_m > 0) cnt_m--;
    cyc(1, 1, 0, '0);
    check({tag, " R2 data"}, dout, e);
    last = dout;
  endtask

  task automatic ofs_wr(input logic [17:0] d, input bit second);
    cyc(0, 0, 1, d);
    if (second) fofs_m = d[11:0]; else eofs_m = d[11:0];
  endtask

  task automatic ofs_rd(input string tag, input int exp);
    cyc(0, 1, 0, '0);
    check({tag, " R4 readback"}, dout, exp);
    last = dout;
  endtask

  task automatic t_reset();
    rst_n = 0;
    cyc(1, 1, 1, '0);
    check("R1 dout during reset", dout, 0);
    check("R1 empty_n", empty_n, 0);
    check("R1 aempty_n", aempty_n, 0);
    check("R1 full/half/afull", {full_n, half_n, afull_n}, 3'b111);
    rst_n = 1;
    cyc(1, 1, 1, '0);
    flags("R1 after release");
    ofs_rd("R1 default eofs", 31);
    ofs_rd("R1 default fofs", 31);
  endtask

  task automatic t_offsets();
    do_reset();
    ofs_wr(18'h3F005, 0);
    ofs_wr(18'h0000A, 1);
    ofs_rd("R3 eofs", 5);
    ofs_rd("R3 fofs", 10);
    ofs_rd("R4 wrap to eofs", 5);
    ofs_wr(18'h00007, 0);
    ofs_rd("R3 write wrapped to eofs, read fofs", 10);
    ofs_rd("R3 eofs rewritten", 7);
    do_reset();
    ofs_wr(18'h00009, 0);
    ofs_rd("R3 sequence restarted by reset", 9);
  endtask

  task automatic t_fill_drain();
    do_reset();
    ofs_wr(18'h00005, 0);
    ofs_wr(18'h0000A, 1);
    flags("fill start");
    for (int i = 0; i < 256; i++) begin
      fwrite(18'(i * 37 + 3));
      flags("fill");
    end
    fwrite(18'h2AAAA);
    flags("R6 write while full");
    for (int i = 0; i < 256; i++) begin
      fread("drain");
      flags("drain");
    end
    fread("R5 read while empty");
    check("R5 empty dout held", dout, 18'((255 * 37 + 3)));
    flags("R5 after empty read");
  endtask

  task automatic t_hold();
    do_reset();
    fwrite(18'h11111);
    fwrite(18'h22222);
    fread("R10 prep");
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 1, 18'(i + 100));
      q.push_back(18'(i + 100)); cnt_m++;
      check("R10 dout held with rd_n high", dout, 18'h11111);
    end
    flags("R10 count");
  endtask

  task automatic t_simul();
    do_reset();
    ofs_wr(18'h00003, 0);
    fwrite(18'h00001); fwrite(18'h00002); fwrite(18'h00003);
    flags("R11 prep");
    for (int i = 0; i < 4; i++) begin
      logic [17:0] e;
      e = q.pop_front();
      q.push_back(18'(i + 16));
      cyc(1, 0, 0, 18'(i + 16));
      check("R11 data order", dout, e);
      check("R11 aempty_n count unchanged", aempty_n, 0);
    end
    fwrite(18'h00055);
    check("R11 count now 4", aempty_n, 1);
  endtask

  task automatic t_cfg_isolation();
    do_reset();
    fwrite(18'h0ABCD);
    ofs_wr(18'h00000, 0);
    check("R12 empty_n after offset write", empty_n, 1);
    check("R12 aempty_n with eofs 0", aempty_n, 1);
    fread("R12 word intact");
    check("R12 now empty", empty_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_offsets();
    t_fill_drain();
    t_hold();
    t_simul();
    t_cfg_isolation();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule